// File: doc/BRIEF.md
# Two-Stage Write-Unlock Register Controller

This block guards a small bank of configuration bytes that behave as slow nonvolatile storage. Software reaches them through a byte-level transaction port. Each transaction is framed by a start strobe and a stop strobe. Inside the frame come a device byte, a register address byte, and then either data bytes to write or read strobes.

A volatile status register holds two guard latches. The first is the write latch. The second is the register-write latch, and it can only be set while the write latch is already set. A configuration write is accepted only when both latches are set, the write ends with a clean stop, and no earlier commit is still running. An accepted write raises `busy_o` for a programmable number of clock cycles. Only at the end of that window do the stored bytes take their new values, and the register-write latch then clears itself, so each further change needs a fresh unlock.

A transaction that is aborted, whether by a repeated start before the stop or by the abort strobe, commits nothing and leaves the latches unchanged. Reads are allowed at any time, including between the unlock steps and during the busy window.

Top module: `wul_unlock_ctrl`

## Requirements
- R1: After reset every configuration byte reads 00h, the status byte reads 00h and `busy_o` is low.
- R2: A status write of 02h sets the write latch with no busy period. The status register sits at address 3Fh. Its read value is bit 0 = busy, bit 1 = write latch, bit 2 = register-write latch, and the other bits are zero. A status write of 02h leaves the register-write latch unchanged.
- R3: A status write of 06h sets the register-write latch only if the write latch is already set. With the write latch clear, 06h has no effect. Any status value other than 00h, 02h or 06h is ignored. The register-write latch is never set while the write latch is clear.
- R4: A status write of 00h clears both latches.
- R5: A configuration write made with both latches set is committed by the stop. `busy_o` rises one cycle after the stop and stays high for exactly PROG_CYCLES cycles. Reads during that window return the old values. When `busy_o` falls, the new bytes are visible and the register-write latch is clear, while the write latch stays set.
- R6: A configuration write made while either latch is clear changes no byte and starts no busy period.
- R7: A write frame that ends in a repeated start or the abort strobe instead of a stop commits nothing and leaves both latches as they were.
- R8: One write frame carries up to MAX_BURST (8) data bytes to consecutive addresses starting at the given address. Bytes past the 8th are dropped. Bytes whose address is at or above NREG (16) are dropped. A frame whose start address is outside the map and is not 3Fh has no effect.
- R9: While `busy_o` is high, every write frame, whether status or configuration, is ignored.
- R10: A read frame (device byte DFh, then an address, then one strobe per byte) returns the addressed byte and increments the address. It never alters either latch, so a read placed between the unlock steps and the write does not cancel the unlock.
- R11: Write frames use device byte DEh. A frame whose device byte is neither DEh nor DFh is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or repeated-start strobe |
| stop_i | input | 1 | Stop strobe |
| abort_i | input | 1 | Frame error strobe (bad bit count) |
| byte_vld_i | input | 1 | A byte is present on byte_i |
| byte_i | input | 8 | Transaction byte |
| rd_vld_o | output | 1 | Read data valid, one cycle |
| rd_data_o | output | 8 | Read data |
| busy_o | output | 1 | Nonvolatile programming in progress |

## Verification
The assertions check four things on every cycle. The register-write latch never stands without the write latch. A commit is launched only with both latches set and never while busy. Every busy window lasts exactly PROG_CYCLES cycles. The stored bytes change only on the cycle the window closes. The bench scenarios are the only way to show the rest: which status values are honoured and in which order, the effect of aborts and repeated starts, burst truncation at eight bytes and at the end of the map, writes ignored while busy, and reads interleaved with the unlock sequence.

// File: rtl/wul_pkg.sv
package wul_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_e;

  localparam logic [7:0] ST_CLEAR    = 8'h00;
  localparam logic [7:0] ST_SET_WEN  = 8'h02;
  localparam logic [7:0] ST_SET_BOTH = 8'h06;

  // Status read layout: bit0 busy, bit1 write latch, bit2 register-write latch
  function automatic logic [7:0] status_byte(input logic busy, input logic wen, input logic rwen);
    return {5'b0, rwen, wen, busy};
  endfunction

  // True when byte index k of a burst starting at base with cnt bytes hits address a
  function automatic logic burst_hits(input logic [7:0] a, input logic [7:0] base, input int cnt);
    return (a >= base) && (int'(a - base) < cnt);
  endfunction

endpackage

// File: rtl/wul_txn_decoder.sv
module wul_txn_decoder
  import wul_pkg::*;
#(
  parameter int          MAX_BURST = 8,
  parameter logic [7:0]  DEV_WR    = 8'hDE,
  parameter logic [7:0]  DEV_RD    = 8'hDF,
  localparam int         CNT_W     = $clog2(MAX_BURST + 1),
  localparam int         IDX_W     = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          stop_i,
  input  logic                          abort_i,
  input  logic                          byte_vld_i,
  input  logic [7:0]                    byte_i,
  output logic                          commit_o,
  output logic [7:0]                    base_o,
  output logic [CNT_W-1:0]              cnt_o,
  output logic [MAX_BURST-1:0][7:0]     data_o,
  output logic                          rd_req_o,
  output logic [7:0]                    rd_addr_o
);

  phase_e              phase_q;
  logic                wr_q;
  logic [7:0]          ptr_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [MAX_BURST-1:0][7:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      wr_q      <= 1'b0;
      ptr_q     <= '0;
      cnt_q     <= '0;
      stage_q   <= '0;
      base_o    <= '0;
      commit_o  <= 1'b0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      commit_o <= 1'b0;
      rd_req_o <= 1'b0;
      if (abort_i) begin
        phase_q <= PH_IDLE;        // R7: framing error drops the frame
        cnt_q   <= '0;
      end else if (start_i) begin
        phase_q <= PH_DEV;         // R7: repeated start discards staged bytes
        cnt_q   <= '0;
      end else if (stop_i) begin
        if (phase_q == PH_WDATA && cnt_q != '0) commit_o <= 1'b1;
        phase_q <= PH_IDLE;
      end else if (byte_vld_i) begin
        unique case (phase_q)
          PH_DEV: begin
            wr_q    <= (byte_i == DEV_WR);
            phase_q <= (byte_i == DEV_WR || byte_i == DEV_RD) ? PH_ADDR : PH_SKIP; // R11
          end
          PH_ADDR: begin
            base_o  <= byte_i;
            ptr_q   <= byte_i;
            phase_q <= wr_q ? PH_WDATA : PH_RDATA;
          end
          PH_WDATA: begin
            if (cnt_q < CNT_W'(MAX_BURST)) begin   // R8: burst capped
              stage_q[cnt_q[IDX_W-1:0]] <= byte_i;
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_RDATA: begin
            rd_req_o  <= 1'b1;
            rd_addr_o <= ptr_q;
            ptr_q     <= ptr_q + 8'd1;   // R10: auto-increment
          end
          default: ;
        endcase
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign data_o = stage_q;

endmodule

// File: rtl/wul_unlock_latch.sv
module wul_unlock_latch
  import wul_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       prog_done_i,
  output logic       wen_o,
  output logic       rwen_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_o  <= 1'b0;
      rwen_o <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_data_i)
        ST_CLEAR: begin        // R4
          wen_o  <= 1'b0;
          rwen_o <= 1'b0;
        end
        ST_SET_WEN: wen_o <= 1'b1;                 // R2
        ST_SET_BOTH: if (wen_o) rwen_o <= 1'b1;    // R3: ordered unlock
        default: ;
      endcase
    end else if (prog_done_i) begin
      rwen_o <= 1'b0;                              // R5
    end
  end

endmodule

// File: rtl/wul_nv_store.sv
module wul_nv_store
  import wul_pkg::*;
#(
  parameter int  NREG        = 16,
  parameter int  MAX_BURST   = 8,
  parameter int  PROG_CYCLES = 500000,
  localparam int CNT_W       = $clog2(MAX_BURST + 1),
  localparam int IDX_W       = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1,
  localparam int TMR_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      launch_i,
  input  logic [7:0]                base_i,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [MAX_BURST-1:0][7:0] data_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [NREG*8-1:0]         regs_o
);

  logic [TMR_W-1:0]      tmr_q;
  logic [NREG-1:0]       mask_d, mask_q;
  logic [NREG-1:0][7:0]  val_d, val_q, mem_q;

  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      logic [7:0] off;
      off       = 8'(k) - base_i;
      mask_d[k] = burst_hits(8'(k), base_i, int'(cnt_i));   // R8
      val_d[k]  = data_i[off[IDX_W-1:0]];
    end
  end

  assign done_o = busy_o && (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      tmr_q  <= '0;
      mask_q <= '0;
      val_q  <= '0;
    end else if (launch_i) begin
      busy_o <= 1'b1;
      tmr_q  <= TMR_W'(PROG_CYCLES - 1);
      mask_q <= mask_d;
      val_q  <= val_d;
    end else if (busy_o) begin
      if (tmr_q == '0) busy_o <= 1'b0;
      else tmr_q <= tmr_q - 1'b1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    mem_q[g] <= 8'h00;   // R1
      else if (done_o && mask_q[g])   mem_q[g] <= val_q[g]; // R5
    end
    assign regs_o[g*8 +: 8] = mem_q[g];
  end

endmodule

// File: rtl/wul_unlock_ctrl.sv
module wul_unlock_ctrl
  import wul_pkg::*;
#(
  parameter int         NREG        = 16,
  parameter int         MAX_BURST   = 8,
  parameter int         PROG_CYCLES = 500000,
  parameter logic [7:0] STAT_ADDR   = 8'h3F,
  parameter logic [7:0] DEV_WR      = 8'hDE,
  parameter logic [7:0] DEV_RD      = 8'hDF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       abort_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       rd_vld_o,
  output logic [7:0] rd_data_o,
  output logic       busy_o
);

  localparam int         CNT_W  = $clog2(MAX_BURST + 1);
  localparam logic [7:0] NREG_B = 8'(NREG);

  logic                      commit_w;
  logic [7:0]                base_w;
  logic [CNT_W-1:0]          cnt_w;
  logic [MAX_BURST-1:0][7:0] stage_w;
  logic                      rd_req_w;
  logic [7:0]                rd_addr_w;
  logic                      wen_w, rwen_w;
  logic                      stat_wr_w, nv_launch_w, nv_done_w;
  logic [NREG*8-1:0]         regs_flat_w;

  wul_txn_decoder #(
    .MAX_BURST(MAX_BURST), .DEV_WR(DEV_WR), .DEV_RD(DEV_RD)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start_i), .stop_i(stop_i), .abort_i(abort_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .commit_o(commit_w), .base_o(base_w), .cnt_o(cnt_w), .data_o(stage_w),
    .rd_req_o(rd_req_w), .rd_addr_o(rd_addr_w)
  );

  // R9: nothing written while a commit runs
  assign stat_wr_w   = commit_w && (base_w == STAT_ADDR) && !busy_o;
  // R6/R8: configuration commit needs both latches and an in-map start
  assign nv_launch_w = commit_w && (base_w < NREG_B) && !busy_o && wen_w && rwen_w;

  wul_unlock_latch u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(stat_wr_w), .wr_data_i(stage_w[0]),
    .prog_done_i(nv_done_w),
    .wen_o(wen_w), .rwen_o(rwen_w)
  );

  wul_nv_store #(
    .NREG(NREG), .MAX_BURST(MAX_BURST), .PROG_CYCLES(PROG_CYCLES)
  ) u_nv (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .launch_i(nv_launch_w), .base_i(base_w), .cnt_i(cnt_w), .data_i(stage_w),
    .busy_o(busy_o), .done_o(nv_done_w), .regs_o(regs_flat_w)
  );

  // R10: reads are side-effect free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o  <= 1'b0;
      rd_data_o <= 8'h00;
    end else begin
      rd_vld_o <= rd_req_w;
      if (rd_req_w) begin
        if (rd_addr_w == STAT_ADDR)  rd_data_o <= status_byte(busy_o, wen_w, rwen_w);
        else if (rd_addr_w < NREG_B) rd_data_o <= regs_flat_w[rd_addr_w*8 +: 8];
        else                         rd_data_o <= 8'h00;
      end
    end
  end

endmodule

// File: rtl/wul_unlock_ctrl_chk.sv
module wul_unlock_ctrl_chk #(
  parameter int NREG        = 16,
  parameter int PROG_CYCLES = 500000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              nv_launch_w,
  input logic              nv_done_w,
  input logic              wen_w,
  input logic              rwen_w,
  input logic [NREG*8-1:0] regs_flat_w
);

  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  a_r3_rwel_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwen_w |-> wen_w);

  a_r6_launch_needs_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_launch_w |-> (wen_w && rwen_w));

  a_r9_no_launch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_launch_w |-> !busy_o);

  a_r5_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len == PROG_CYCLES));

  a_r5_regs_change_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_flat_w) |-> $past(nv_done_w));

  a_r5_rwel_clear_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_done_w |=> !rwen_w);

endmodule

bind wul_unlock_ctrl wul_unlock_ctrl_chk #(
  .NREG(NREG), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o),
  .nv_launch_w(nv_launch_w), .nv_done_w(nv_done_w),
  .wen_w(wen_w), .rwen_w(rwen_w), .regs_flat_w(regs_flat_w)
);

// File: tb/wul_unlock_ctrl_tb_top.sv
module wul_unlock_ctrl_tb_top;

  localparam int PROG = 40;
  localparam logic [7:0] ST = 8'h3F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, stop = 0, abort = 0, bvld = 0;
  logic [7:0] bdat = 8'h00;
  logic rd_vld;
  logic [7:0] rd_data;
  logic busy;

  int n_chk = 0, n_fail = 0;
  logic [7:0] wbuf [16];
  logic [7:0] v;

  always #10 clk = ~clk;

  wul_unlock_ctrl #(.PROG_CYCLES(PROG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .abort_i(abort),
    .byte_vld_i(bvld), .byte_i(bdat), .rd_vld_o(rd_vld), .rd_data_o(rd_data), .busy_o(busy)
  );

  // status write value, expected write latch, expected register-write latch
  localparam logic [9:0] VEC [10] = '{
    {8'h00, 1'b0, 1'b0}, {8'h06, 1'b0, 1'b0}, {8'h02, 1'b1, 1'b0}, {8'h55, 1'b1, 1'b0},
    {8'h06, 1'b1, 1'b1}, {8'h02, 1'b1, 1'b1}, {8'h04, 1'b1, 1'b1}, {8'h00, 1'b0, 1'b0},
    {8'h02, 1'b1, 1'b0}, {8'h06, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic p_start; @(negedge clk) start = 1; @(negedge clk) start = 0; endtask
  task automatic p_abort; @(negedge clk) abort = 1; @(negedge clk) abort = 0; endtask
  task automatic p_stop;  @(negedge clk) stop = 1;  @(negedge clk) stop = 0; @(negedge clk); endtask
  task automatic p_byte(input logic [7:0] b);
    @(negedge clk) begin bvld = 1; bdat = b; end
    @(negedge clk) bvld = 0;
  endtask

  task automatic wr_frame(input logic [7:0] dev, input logic [7:0] a, input int n);
    p_start; p_byte(dev); p_byte(a);
    for (int i = 0; i < n; i++) p_byte(wbuf[i]);
    p_stop;
  endtask

  task automatic st_wr(input logic [7:0] val);
    wbuf[0] = val; wr_frame(8'hDE, ST, 1);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] res);
    p_start; p_byte(8'hDF); p_byte(a);
    @(negedge clk) bvld = 1;
    @(negedge clk) bvld = 0;
    @(negedge clk) res = rd_data;
    p_stop;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy) begin cycles++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {7'b0, busy}, 8'h00);
    rd(ST, v);   check("R1 status", v, 8'h00);
    rd(8'd5, v); check("R1 reg5", v, 8'h00);

    // status sequence table: R2 R3 R4
    for (int i = 0; i < 10; i++) begin
      st_wr(VEC[i][9:2]);
      check("R2/R3/R4 busy after status write", {7'b0, busy}, 8'h00);
      rd(ST, v);
      check("R2/R3/R4 status", v, {5'b0, VEC[i][0], VEC[i][1], 1'b0});
    end

    // R5 commit with old values visible during busy
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    wr_frame(8'hDE, 8'd2, 3);
    check("R5 busy high", {7'b0, busy}, 8'h01);
    rd(8'd2, v);  check("R5 old value during busy", v, 8'h00);
    rd(ST, v);    check("R10 status during busy", v, 8'h07);
    wait_idle(cyc);
    rd(8'd2, v);  check("R5 reg2", v, 8'hAA);
    rd(8'd4, v);  check("R5 reg4", v, 8'hCC);
    rd(ST, v);    check("R5 rwel cleared", v, 8'h02);

    // R5 exact busy length
    st_wr(8'h06);
    wbuf[0] = 8'h5A; wr_frame(8'hDE, 8'd9, 1);
    wait_idle(cyc);
    check("R5 busy cycles", 8'(cyc), 8'(PROG));
    rd(8'd9, v);  check("R5 reg9", v, 8'h5A);

    // R6 writes without full unlock
    wbuf[0] = 8'h11; wr_frame(8'hDE, 8'd0, 1);
    check("R6 no busy wel only", {7'b0, busy}, 8'h00);
    rd(8'd0, v);  check("R6 reg0 wel only", v, 8'h00);
    st_wr(8'h00);
    wr_frame(8'hDE, 8'd0, 1);
    rd(8'd0, v);  check("R6 reg0 locked", v, 8'h00);

    // R7 aborts
    st_wr(8'h02); st_wr(8'h06);
    p_start; p_byte(8'hDE); p_byte(8'd0); p_byte(8'h77); p_start; p_stop;
    check("R7 repeated start no busy", {7'b0, busy}, 8'h00);
    rd(8'd0, v);  check("R7 repeated start reg0", v, 8'h00);
    rd(ST, v);    check("R7 latches kept", v, 8'h06);
    p_start; p_byte(8'hDE); p_byte(8'd0); p_byte(8'h77); p_abort; p_stop;
    check("R7 abort no busy", {7'b0, busy}, 8'h00);
    rd(8'd0, v);  check("R7 abort reg0", v, 8'h00);

    // R8 bursts: map end and 8-byte cap
    for (int i = 0; i < 10; i++) wbuf[i] = 8'h80 + 8'(i);
    wr_frame(8'hDE, 8'd12, 10);
    wait_idle(cyc);
    rd(8'd12, v); check("R8 reg12", v, 8'h80);
    rd(8'd15, v); check("R8 reg15", v, 8'h83);
    rd(8'd0, v);  check("R8 no wrap", v, 8'h00);
    st_wr(8'h06);
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hC0 + 8'(i);
    wr_frame(8'hDE, 8'd0, 10);
    wait_idle(cyc);
    rd(8'd7, v);  check("R8 reg7", v, 8'hC7);
    rd(8'd8, v);  check("R8 ninth byte dropped", v, 8'h00);
    rd(8'd9, v);  check("R8 tenth byte dropped", v, 8'h5A);

    // R9 writes ignored while busy
    st_wr(8'h06);
    wbuf[0] = 8'hA1; wr_frame(8'hDE, 8'd10, 1);
    st_wr(8'h00);
    wbuf[0] = 8'hB2; wr_frame(8'hDE, 8'd11, 1);
    wait_idle(cyc);
    rd(ST, v);     check("R9 status clear ignored", v, 8'h02);
    rd(8'd11, v);  check("R9 reg11", v, 8'h00);
    rd(8'd10, v);  check("R9 reg10", v, 8'hA1);

    // R10 reads between unlock steps
    st_wr(8'h00); st_wr(8'h02);
    rd(8'd10, v);  check("R10 read between steps", v, 8'hA1);
    st_wr(8'h06);
    rd(ST, v);     check("R10 unlock kept", v, 8'h06);
    wbuf[0] = 8'h3C; wr_frame(8'hDE, 8'd13, 1);
    wait_idle(cyc);
    rd(8'd13, v);  check("R10 write after reads", v, 8'h3C);

    // R11 foreign device byte, R8 out-of-map start
    st_wr(8'h06);
    wbuf[0] = 8'h99; wr_frame(8'hA0, 8'd1, 1);
    check("R11 no busy", {7'b0, busy}, 8'h00);
    rd(8'd1, v);   check("R11 reg1", v, 8'hC1);
    wr_frame(8'hDE, 8'h20, 1);
    check("R8 out-of-map no busy", {7'b0, busy}, 8'h00);
    rd(ST, v);     check("R8 out-of-map latches", v, 8'h06);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule